// File: doc/BRIEF.md
# Multi-Wide Instruction Fetch Queue

This block is an elastic buffer that sits between instruction fetch and dispatch. In one cycle the fetch side hands over a packet of up to four 32-bit instructions on a 128-bit bus, together with a per-slot valid mask. The dispatch side always sees the four oldest queued instructions, each with its own valid flag. Each cycle it states how many of them, from zero to four, it takes from the head.

Because both rates vary from cycle to cycle, the queue takes up the difference. It accepts a packet only when it has room for all four slots, so a packet is never split. Instructions leave strictly in arrival order. A flush empties the queue at once, for example after a redirect of the fetch stream. The depth is a power-of-two parameter of at least eight. Read and write pointers carry one extra bit, so that a full queue can be told from an empty one.

Top module: `fetch_queue`

## Requirements
- R1: After synchronous reset the queue is empty: all four window valid flags are 0 and the fetch ready output is 1.
- R2: A packet is accepted on a clock edge where the packet valid input and the ready output are both 1 and flush is 0. Only the slots whose mask bit is 1 are stored. Slot k is bits [32k+31:32k] of the packet. Stored slots keep ascending slot order and close up over the gaps left by cleared mask bits.
- R3: Window position i (bits [32i+31:32i], valid flag bit i) shows the i-th oldest entry. Its flag is 1 exactly when more than i entries are queued. An accepted packet becomes visible from the cycle after its accepting edge.
- R4: A dequeue count n removes the n oldest entries at the clock edge. The remaining entries move toward window position 0 in order.
- R5: A dequeue count larger than the number of queued entries removes only the entries present and leaves the queue empty.
- R6: Ready is 1 exactly when at least four entries are free. A packet offered while ready is 0 is ignored and changes nothing.
- R7: A flush empties the queue at the next edge. It takes priority over a packet and a dequeue count presented in the same cycle, so neither has any effect.
- R8: The queue holds exactly the depth (default 16) entries when full. Program order is preserved while the pointers wrap around the storage many times.
- R9: In one cycle both an enqueue and a dequeue may occur. The dequeue removes from the existing head, and the new packet is appended behind the entries that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Fetch packet offered |
| pkt_mask | input | 4 | Per-slot valid mask of the packet |
| pkt_data | input | 128 | Four 32-bit instruction slots |
| pkt_ready | output | 1 | At least four entries free |
| deq_count | input | 3 | Number of oldest entries to remove (0..4) |
| flush | input | 1 | Empty the queue |
| win_valid | output | 4 | Valid flags of the four oldest entries |
| win_data | output | 128 | The four oldest instructions, oldest in bits [31:0] |

## Verification
Every result is due one edge after its stimulus. A packet, a dequeue or a flush takes effect at the edge where it is presented. The window and ready outputs, which are decoded from registered state alone, show the effect from that edge on. Ready is also checked before each edge, because it decides whether the packet in that cycle is taken. The bench drives inputs after the falling edge and samples at the next falling edge, exactly one edge later. It compares the outputs against a reference queue that it updates with the same one-edge rule.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    localparam int LANES   = 4;
    localparam int IW      = 32;
    localparam int LW      = $clog2(LANES);
    localparam int CW      = $clog2(LANES + 1);

    typedef logic [IW-1:0] instr_t;

    typedef struct packed {
        logic [LANES-1:0]         mask;
        instr_t [LANES-1:0]       word;
    } packet_t;

    typedef struct packed {
        logic [CW-1:0]            n;
        instr_t [LANES-1:0]       word;
    } dense_t;

    function automatic logic [CW-1:0] pop_lanes(input logic [LANES-1:0] m);
        logic [CW-1:0] c;
        c = '0;
        for (int i = 0; i < LANES; i++) begin
            c = c + CW'(m[i]);
        end
        return c;
    endfunction
endpackage

// File: rtl/ifq_compact.sv
module ifq_compact
    import ifq_pkg::*;
(
    input  packet_t pkt,
    output dense_t  dn
);
    always_comb begin
        logic [CW-1:0] pos;
        dn  = '0;
        pos = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pkt.mask[i]) begin
                dn.word[pos[LW-1:0]] = pkt.word[i];
                pos = pos + 1'b1;
            end
        end
        dn.n = pos;
    end
endmodule

// File: rtl/ifq_ptrs.sv
module ifq_ptrs
    import ifq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          offer,
    input  logic [CW-1:0] n_in,
    input  logic [CW-1:0] deq_req,
    output logic          rdy,
    output logic          fire,
    output logic [CW-1:0] n_out,
    output logic [PW:0]   head_q,
    output logic [PW:0]   tail_q,
    output logic [PW:0]   fill
);
    localparam logic [PW:0] ROOM_LIMIT = (PW+1)'(DEPTH - LANES);

    logic [PW:0] req_wide;

    assign fill     = tail_q - head_q;
    assign rdy      = (fill <= ROOM_LIMIT);
    assign fire     = offer && rdy && !flush;
    assign req_wide = {{(PW+1-CW){1'b0}}, deq_req};

    always_comb begin
        if (flush)
            n_out = '0;
        else if (req_wide > fill)
            n_out = fill[CW-1:0];
        else
            n_out = deq_req;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + {{(PW+1-CW){1'b0}}, n_out};
            if (fire)
                tail_q <= tail_q + {{(PW+1-CW){1'b0}}, n_in};
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill <= (PW+1)'(DEPTH)) else $error("occupancy above depth"); // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill == '0)) else $error("flush left entries"); // R7

    AST_DEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!flush && !fire) |=> (fill == $past(fill) - {{(PW+1-CW){1'b0}}, $past(n_out)}))
        else $error("dequeue step wrong"); // R4

    AST_BLOCKED_OFFER: assert property (@(posedge clk) disable iff (rst)
        (offer && !rdy && !flush) |=> (fill <= $past(fill)))
        else $error("offer taken without room"); // R6

    AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!flush && !fire && (deq_req > fill[CW-1:0]) && (fill <= (PW+1)'(LANES))) |=> (fill == '0))
        else $error("excess dequeue not clamped"); // R5
endmodule

// File: rtl/ifq_store.sv
module ifq_store
    import ifq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [PW-1:0]      wr_idx,
    input  dense_t             dn,
    input  logic [PW-1:0]      rd_idx,
    output instr_t [LANES-1:0] win
);
    instr_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < LANES; k++) begin
                if (CW'(k) < dn.n)
                    mem[wr_idx + PW'(k)] <= dn.word[k];
            end
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_win
        assign win[i] = mem[rd_idx + PW'(i)];
    end
endmodule

// File: rtl/fetch_queue.sv
module fetch_queue
    import ifq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pkt_valid,
    input  logic [LANES-1:0]    pkt_mask,
    input  logic [LANES*IW-1:0] pkt_data,
    output logic                pkt_ready,
    input  logic [CW-1:0]       deq_count,
    input  logic                flush,
    output logic [LANES-1:0]    win_valid,
    output logic [LANES*IW-1:0] win_data
);
    initial begin
        assert (DEPTH >= 8 && (DEPTH & (DEPTH - 1)) == 0)
            else $error("depth must be a power of two, at least eight");
    end

    packet_t            pkt;
    dense_t             dn;
    logic               fire;
    logic [CW-1:0]      n_out;
    logic [PW:0]        head_q, tail_q, fill;
    instr_t [LANES-1:0] win;

    assign pkt.mask = pkt_mask;
    assign pkt.word = pkt_data;

    ifq_compact u_compact (
        .pkt (pkt),
        .dn  (dn)
    );

    ifq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .offer   (pkt_valid),
        .n_in    (dn.n),
        .deq_req (deq_count),
        .rdy     (pkt_ready),
        .fire    (fire),
        .n_out   (n_out),
        .head_q  (head_q),
        .tail_q  (tail_q),
        .fill    (fill)
    );

    ifq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .we     (fire),
        .wr_idx (tail_q[PW-1:0]),
        .dn     (dn),
        .rd_idx (head_q[PW-1:0]),
        .win    (win)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign win_valid[i] = (fill > (PW+1)'(i));
    end
    assign win_data = win;

    for (genvar i = 1; i < LANES; i++) begin : g_chk
        AST_WIN_CONTIG: assert property (@(posedge clk) disable iff (rst)
            win_valid[i] |-> win_valid[i-1]) else $error("window has a gap"); // R3
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $past(rst) |-> (win_valid == '0 && pkt_ready)) else $error("not empty after reset"); // R1
endmodule

// File: tb/tb_fetch_queue.sv
module tb_fetch_queue;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pkt_valid = 1'b0;
    logic [3:0]   pkt_mask = '0;
    logic [127:0] pkt_data = '0;
    logic         pkt_ready;
    logic [2:0]   deq_count = '0;
    logic         flush = 1'b0;
    logic [3:0]   win_valid;
    logic [127:0] win_data;

    int checks = 0;
    int fails  = 0;
    int seq    = 0;
    bit done   = 0;
    logic [31:0] mq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_queue #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_mask(pkt_mask),
        .pkt_data(pkt_data), .pkt_ready(pkt_ready), .deq_count(deq_count),
        .flush(flush), .win_valid(win_valid), .win_data(win_data)
    );

    task automatic check_window(input string tag);
        logic [3:0]   ev;
        logic [127:0] ed;
        logic [127:0] ad;
        ev = '0; ed = '0; ad = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < mq.size()) begin
                ev[i] = 1'b1;
                ed[32*i +: 32] = mq[i];
                ad[32*i +: 32] = win_data[32*i +: 32];
            end
        end
        checks++;
        if (win_valid !== ev || ad !== ed) begin
            fails++;
            $display("FAIL %s window: valid %b data %h, expected valid %b data %h",
                     tag, win_valid, ad, ev, ed);
        end
    endtask

    task automatic check_ready(input string tag);
        logic er;
        er = (mq.size() <= DEPTH - 4);
        checks++;
        if (pkt_ready !== er) begin
            fails++;
            $display("FAIL %s ready: got %b expected %b (held %0d)", tag, pkt_ready, er, mq.size());
        end
    endtask

    task automatic cycle(input logic v, input logic [3:0] m, input logic [2:0] d,
                         input logic f, input string tag);
        logic [127:0] data;
        logic         rdy_now;
        for (int k = 0; k < 4; k++) begin
            seq++;
            data[32*k +: 32] = 32'hC000_0000 + 32'(seq);
        end
        pkt_valid = v; pkt_mask = m; pkt_data = data; deq_count = d; flush = f;
        #1;
        check_ready(tag);
        rdy_now = (mq.size() <= DEPTH - 4);
        if (f) begin
            mq.delete();
        end else begin
            for (int k = 0; k < int'(d) && mq.size() > 0; k++) void'(mq.pop_front());
            if (v && rdy_now)
                for (int k = 0; k < 4; k++) if (m[k]) mq.push_back(data[32*k +: 32]);
        end
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0; pkt_mask = '0; deq_count = '0; flush = 1'b0;
        check_window(tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mq.delete();
        check_ready("R1");
        check_window("R1");
    endtask

    task automatic t_packets;
        cycle(1, 4'b1111, 0, 0, "R2");
        cycle(1, 4'b1010, 0, 0, "R2");
        cycle(1, 4'b0001, 0, 0, "R3");
        cycle(0, 4'b0000, 0, 0, "R3");
    endtask

    task automatic t_dequeue;
        cycle(0, 4'b0000, 1, 0, "R4");
        cycle(0, 4'b0000, 3, 0, "R4");
        cycle(0, 4'b0000, 4, 0, "R5");
        cycle(1, 4'b0110, 0, 0, "R2");
        cycle(0, 4'b0000, 4, 0, "R5");
        cycle(0, 4'b0000, 2, 0, "R5");
    endtask

    task automatic t_simul;
        cycle(1, 4'b1111, 0, 0, "R9");
        cycle(1, 4'b1101, 2, 0, "R9");
        cycle(1, 4'b1111, 4, 0, "R9");
        cycle(0, 4'b0000, 4, 0, "R9");
        cycle(0, 4'b0000, 4, 0, "R9");
    endtask

    task automatic t_full;
        while (mq.size() <= DEPTH - 4) cycle(1, 4'b1111, 0, 0, "R8");
        cycle(1, 4'b1111, 0, 0, "R6");
        cycle(1, 4'b1111, 0, 0, "R6");
        checks++;
        if (mq.size() != DEPTH) begin
            fails++;
            $display("FAIL R8 occupancy model %0d expected %0d", mq.size(), DEPTH);
        end
        for (int k = 0; k < 4; k++) cycle(0, 4'b0000, 4, 0, "R8");
    endtask

    task automatic t_wrap;
        for (int r = 0; r < 20; r++) cycle(1, 4'b1111, 3, 0, "R8");
        for (int r = 0; r < 6; r++) cycle(0, 4'b0000, 4, 0, "R8");
    endtask

    task automatic t_flush;
        cycle(1, 4'b1111, 0, 0, "R7");
        cycle(1, 4'b0111, 0, 0, "R7");
        cycle(1, 4'b1111, 2, 1, "R7");
        cycle(0, 4'b0000, 0, 0, "R7");
        cycle(1, 4'b1001, 0, 0, "R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_packets();
        t_dequeue();
        t_simul();
        t_full();
        t_wrap();
        t_flush();
        t_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule